// File: doc/BRIEF.md
# Doorbell Command Mailbox

This block is the device-side register file of a host-to-device command mailbox. The host first waits until the block reports that it is ready. It then writes a command word holding an opcode and an input byte count, and fills a byte-addressable payload buffer. Writing a one to the doorbell bit submits the command. From that point the device's command engine owns the mailbox. It receives a start pulse, reads the opcode, the input length and the input bytes, and writes its output bytes into the same buffer. It then raises a done strobe carrying a return code and an output byte count.

The done strobe stores the result and clears the doorbell, which hands the mailbox back to the host. The host reads the return code from the status register. On success it also reads the output length from the command register and then the output bytes. Ownership follows the doorbell. When the doorbell is clear, only the host can change the mailbox. When it is set, only the device can. Results therefore stay frozen until the host submits the next command.

Host accesses use a single address space. A top address bit of zero selects a register by index in the low three bits. A top address bit of one selects a byte of the payload buffer. Read data appears on the cycle after the address is presented.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, reads of the control register (index 1), the command register (index 2), the status register (index 3) and the device-status register (index 4) all return zero. `mbxReady` is low.
- R2: `mbxReady` and device-status bit 0 go high `READY_DELAY` cycles after reset is released and stay high. A doorbell write made before that has no effect.
- R3: The capability register (index 0) returns the buffer-size exponent in bits [4:0]. The exponent is clamped to the range 8 to 20, so the buffer holds 2^exponent bytes, from 256 bytes up to 1 MiB.
- R4: A host write with bit 0 set to the control register sets the doorbell (control bit 0, also `devBusy`). One cycle after that, `devStart` pulses for exactly one cycle. `devOpcode` and `devInLen` then show command bits [15:0] and [36:16].
- R5: While the doorbell is set, host writes to the command register and to the payload buffer are ignored.
- R6: The host cannot clear the doorbell. Only `devDone` while the doorbell is set clears it.
- R7: `devDone` while the doorbell is set has three effects. It stores `devRetCode` in status bits [47:32], where zero means success. It replaces command bits [36:16] with the output length. It clears the doorbell. The opcode is kept.
- R8: An output length larger than the buffer is stored as the buffer size.
- R9: While the doorbell is clear, device payload writes and `devDone` are ignored. Status, command and payload then stay as last written.
- R10: Bytes that the device writes while the doorbell is set can be read back by the host at payload addresses. Host payload writes can be read back by the device through `devRdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | SIZE_EXP+1 | Host address: top bit selects payload, otherwise register index in [2:0] |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 64 | Host write data (payload bytes use [7:0]) |
| hostRdata | output | 64 | Host read data, one cycle after the address |
| mbxReady | output | 1 | Mailbox interface ready |
| devStart | output | 1 | One-cycle pulse when a command is submitted |
| devBusy | output | 1 | Doorbell state |
| devOpcode | output | 16 | Submitted opcode |
| devInLen | output | 21 | Submitted input byte count |
| devAddr | input | SIZE_EXP | Device payload byte address |
| devWe | input | 1 | Device payload write strobe |
| devWdata | input | 8 | Device payload write byte |
| devRdata | output | 8 | Payload byte at devAddr |
| devDone | input | 1 | Command completion strobe |
| devRetCode | input | 16 | Return code sampled with devDone |
| devOutLen | input | 21 | Output byte count sampled with devDone |

## Verification
A host write to the command register can land in the same clock cycle as the device's completion strobe. In that cycle the doorbell is still set, so the host write must be dropped and the device's result must be kept. The bench provokes this by driving `hostWr` to the command register and `devDone` on the same edge. It then reads back the command and status registers and expects the device's output length, the original opcode and the device's return code, with no trace of the host's value.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  localparam int OPC_W = 16;
  localparam int LEN_W = 21;
  localparam int RC_W  = 16;
  localparam int REG_W = 64;

  localparam logic [2:0] IDX_CAP  = 3'd0;
  localparam logic [2:0] IDX_CTRL = 3'd1;
  localparam logic [2:0] IDX_CMD  = 3'd2;
  localparam logic [2:0] IDX_STAT = 3'd3;
  localparam logic [2:0] IDX_DEV  = 3'd4;

  typedef struct packed {
    logic cmdWe;     // host command register write accepted
    logic payWe;     // host payload write accepted
    logic resLoad;   // device completion accepted
    logic devPayWe;  // device payload write accepted
  } mbxStrobes_t;
endpackage

// File: rtl/cmd_mailbox_ctrl.sv
module cmd_mailbox_ctrl
  import cmd_mailbox_pkg::*;
#(
  parameter int AW          = 9,
  parameter int READY_DELAY = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] hostAddr,
  input  logic          hostWr,
  input  logic          hostBit0,
  input  logic          devWe,
  input  logic          devDone,
  output mbxStrobes_t   strobes,
  output logic          doorbell,
  output logic          ready,
  output logic          devStart
);
  localparam int CNT_W = $clog2(READY_DELAY + 2);

  logic [CNT_W-1:0] readyCnt;
  logic dbPrev;
  logic isPay, ringReq;
  logic [2:0] regIdx;

  assign isPay   = hostAddr[AW-1];
  assign regIdx  = hostAddr[2:0];
  assign ringReq = hostWr && !isPay && regIdx == IDX_CTRL && hostBit0 && ready && !doorbell;

  always_comb begin
    strobes.cmdWe    = hostWr && !isPay && regIdx == IDX_CMD && !doorbell;
    strobes.payWe    = hostWr && isPay && !doorbell;
    strobes.resLoad  = doorbell && devDone;
    strobes.devPayWe = doorbell && devWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyCnt <= '0;
      ready    <= 1'b0;
    end else if (readyCnt != CNT_W'(READY_DELAY)) begin
      readyCnt <= readyCnt + 1'b1;
      ready    <= (readyCnt + 1'b1) == CNT_W'(READY_DELAY);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doorbell <= 1'b0;
      dbPrev   <= 1'b0;
    end else begin
      dbPrev <= doorbell;
      if (ringReq)
        doorbell <= 1'b1;
      else if (strobes.resLoad)
        doorbell <= 1'b0;
    end
  end

  assign devStart = doorbell && !dbPrev;

  // R6
  db_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doorbell) |-> $past(devDone));
  // R2
  ring_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doorbell) |-> $past(ready));
  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(ready));
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    devStart |=> !devStart);
endmodule

// File: rtl/cmd_mailbox_data.sv
module cmd_mailbox_data
  import cmd_mailbox_pkg::*;
#(
  parameter int EXP = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbxStrobes_t      strobes,
  input  logic             doorbell,
  input  logic             ready,
  input  logic [EXP:0]     hostAddr,
  input  logic [REG_W-1:0] hostWdata,
  output logic [REG_W-1:0] hostRdata,
  input  logic [EXP-1:0]   devAddr,
  input  logic [7:0]       devWdata,
  output logic [7:0]       devRdata,
  input  logic [RC_W-1:0]  devRetCode,
  input  logic [LEN_W-1:0] devOutLen,
  output logic [OPC_W-1:0] opcode,
  output logic [LEN_W-1:0] lenField
);
  localparam int BUF_BYTES = 1 << EXP;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUF_BYTES);

  logic [7:0] payMem [BUF_BYTES];
  logic [RC_W-1:0] retCode;
  logic [LEN_W-1:0] satLen;

  assign satLen = (devOutLen > MAX_LEN) ? MAX_LEN : devOutLen;

  always_ff @(posedge clk) begin
    if (strobes.payWe)
      payMem[hostAddr[EXP-1:0]] <= hostWdata[7:0];
    else if (strobes.devPayWe)
      payMem[devAddr] <= devWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode   <= '0;
      lenField <= '0;
      retCode  <= '0;
    end else if (strobes.cmdWe) begin
      opcode   <= hostWdata[OPC_W-1:0];
      lenField <= hostWdata[OPC_W +: LEN_W];
    end else if (strobes.resLoad) begin
      lenField <= satLen;
      retCode  <= devRetCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (hostAddr[EXP]) begin
      hostRdata <= {56'd0, payMem[hostAddr[EXP-1:0]]};
    end else begin
      unique case (hostAddr[2:0])
        IDX_CAP:  hostRdata <= REG_W'(EXP);
        IDX_CTRL: hostRdata <= REG_W'(doorbell);
        IDX_CMD:  hostRdata <= {27'd0, lenField, opcode};
        IDX_STAT: hostRdata <= {16'd0, retCode, 32'd0};
        IDX_DEV:  hostRdata <= REG_W'(ready);
        default:  hostRdata <= '0;
      endcase
    end
  end

  assign devRdata = payMem[devAddr];

  // R9
  status_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!doorbell) |-> $stable(retCode));
  // R5
  cmd_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(doorbell) && !$past(strobes.resLoad)) |-> ($stable(opcode) && $stable(lenField)));
  // R8
  len_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resLoad |=> lenField <= MAX_LEN);
  // R7
  opcode_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resLoad |=> $stable(opcode));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int SIZE_EXP    = 8,
  parameter int READY_DELAY = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SIZE_EXP:0]   hostAddr,
  input  logic                hostWr,
  input  logic [63:0]         hostWdata,
  output logic [63:0]         hostRdata,
  output logic                mbxReady,
  output logic                devStart,
  output logic                devBusy,
  output logic [15:0]         devOpcode,
  output logic [20:0]         devInLen,
  input  logic [SIZE_EXP-1:0] devAddr,
  input  logic                devWe,
  input  logic [7:0]          devWdata,
  output logic [7:0]          devRdata,
  input  logic                devDone,
  input  logic [15:0]         devRetCode,
  input  logic [20:0]         devOutLen
);
  localparam int EFF_EXP = (SIZE_EXP > 20) ? 20 : ((SIZE_EXP < 8) ? 8 : SIZE_EXP);

  mbxStrobes_t strobes;
  logic doorbell;

  cmd_mailbox_ctrl #(.AW(SIZE_EXP + 1), .READY_DELAY(READY_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostBit0(hostWdata[0]), .devWe(devWe), .devDone(devDone),
    .strobes(strobes), .doorbell(doorbell), .ready(mbxReady), .devStart(devStart));

  logic [EFF_EXP:0]   dAddr;
  logic [EFF_EXP-1:0] dDevAddr;
  assign dAddr    = {hostAddr[SIZE_EXP], (EFF_EXP)'(hostAddr[SIZE_EXP-1:0])};
  assign dDevAddr = (EFF_EXP)'(devAddr);

  cmd_mailbox_data #(.EXP(EFF_EXP)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .doorbell(doorbell), .ready(mbxReady),
    .hostAddr(dAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .devAddr(dDevAddr), .devWdata(devWdata), .devRdata(devRdata),
    .devRetCode(devRetCode), .devOutLen(devOutLen),
    .opcode(devOpcode), .lenField(devInLen));

  assign devBusy = doorbell;
endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
  localparam int EXP = 8;
  logic clk = 0, rstN = 0;
  logic [EXP:0] hostAddr = '0;
  logic hostWr = 0;
  logic [63:0] hostWdata = '0, hostRdata;
  logic mbxReady, devStart, devBusy;
  logic [15:0] devOpcode;
  logic [20:0] devInLen;
  logic [EXP-1:0] devAddr = '0;
  logic devWe = 0, devDone = 0;
  logic [7:0] devWdata = '0, devRdata;
  logic [15:0] devRetCode = '0;
  logic [20:0] devOutLen = '0;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmd_mailbox #(.SIZE_EXP(EXP), .READY_DELAY(20)) u_dut (.*);

  // {opcode, inLen, retCode, outLen, expectedLen}
  localparam logic [94:0] VEC [4] = '{
    {16'h0001, 21'd4,   16'h0000, 21'd16,       21'd16},
    {16'h4500, 21'd256, 16'h0000, 21'd256,      21'd256},
    {16'h0102, 21'd0,   16'h0005, 21'd8,        21'd8},
    {16'hCAFE, 21'd7,   16'h0000, 21'h1FFFFF,   21'd256}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [EXP:0] a, logic [63:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWr = 1;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic hread(logic [EXP:0] a, output logic [63:0] d);
    @(negedge clk); hostAddr = a;
    @(negedge clk); d = hostRdata;
  endtask

  task automatic dwrite(logic [EXP-1:0] a, logic [7:0] d);
    @(negedge clk); devAddr = a; devWdata = d; devWe = 1;
    @(negedge clk); devWe = 0;
  endtask

  task automatic ddone(logic [15:0] rc, logic [20:0] len);
    @(negedge clk); devRetCode = rc; devOutLen = len; devDone = 1;
    @(negedge clk); devDone = 0;
  endtask

  function automatic logic [EXP:0] reg_a(int idx); return (EXP+1)'(idx); endfunction
  function automatic logic [EXP:0] pay_a(int b); return {1'b1, EXP'(b)}; endfunction

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 mbxReady", mbxReady, 0);
    hread(reg_a(1), r); check("R1 ctrl", r, 0);
    hread(reg_a(2), r); check("R1 cmd", r, 0);
    hread(reg_a(3), r); check("R1 status", r, 0);
    hread(reg_a(4), r); check("R1 devstat", r, 0);
    // R3 capability
    hread(reg_a(0), r); check("R3 cap", r[4:0], EXP);
    // R2 doorbell before ready ignored
    hwrite(reg_a(1), 64'd1);
    hread(reg_a(1), r); check("R2 early doorbell", r, 0);
    check("R2 devBusy early", devBusy, 0);
    repeat (20) @(negedge clk);
    check("R2 mbxReady", mbxReady, 1);
    hread(reg_a(4), r); check("R2 devstat", r, 1);

    foreach (VEC[i]) begin
      logic [15:0] opc, rc; logic [20:0] inLen, outLen, expLen;
      {opc, inLen, rc, outLen, expLen} = VEC[i];
      hwrite(reg_a(2), {27'd0, inLen, opc});
      hwrite(pay_a(i), 64'hA0 + 64'(i));
      devAddr = EXP'(i);
      hwrite(reg_a(1), 64'd1);
      check("R4 devStart", devStart, 1);
      check("R4 devOpcode", devOpcode, opc);
      check("R4 devInLen", devInLen, inLen);
      check("R10 devRdata", devRdata, 8'hA0 + 8'(i));
      @(negedge clk);
      check("R4 start single", devStart, 0);
      dwrite(EXP'(i + 1), 8'h5A ^ 8'(i));
      ddone(rc, outLen);
      hread(reg_a(1), r); check("R7 doorbell clear", r, 0);
      hread(reg_a(3), r); check("R7 retcode", r[47:32], rc);
      hread(reg_a(2), r);
      check(expLen != outLen ? "R8 saturated len" : "R7 out len", r[36:16], expLen);
      check("R7 opcode kept", r[15:0], opc);
      if (rc == 0) begin
        hread(pay_a(i + 1), r); check("R10 payload out", r, 64'h5A ^ 64'(i));
      end
    end

    // R5 / R6 directed
    hwrite(reg_a(2), {27'd0, 21'd2, 16'h1111});
    hwrite(reg_a(1), 64'd1);
    hwrite(reg_a(2), {27'd0, 21'd9, 16'h2222});
    hwrite(pay_a(0), 64'hEE);
    devAddr = '0;
    @(negedge clk);
    check("R5 cmd ignored", devOpcode, 16'h1111);
    check("R5 len ignored", devInLen, 21'd2);
    check("R5 payload ignored", devRdata, 8'hA0);
    hwrite(reg_a(1), 64'd0);
    hread(reg_a(1), r); check("R6 host clear ignored", r, 1);
    // same-cycle host command write and completion
    @(negedge clk);
    hostAddr = reg_a(2); hostWdata = {27'd0, 21'd30, 16'h3333}; hostWr = 1;
    devRetCode = 16'h0007; devOutLen = 21'd3; devDone = 1;
    @(negedge clk); hostWr = 0; devDone = 0;
    hread(reg_a(2), r);
    check("R7 collide len", r[36:16], 21'd3);
    check("R5 collide opcode", r[15:0], 16'h1111);
    hread(reg_a(3), r); check("R7 collide rc", r[47:32], 16'h0007);
    // R9 device activity while idle
    dwrite('0, 8'h77);
    ddone(16'h0009, 21'd5);
    hread(pay_a(0), r); check("R9 dev write ignored", r, 64'hA0);
    hread(reg_a(3), r); check("R9 status kept", r[47:32], 16'h0007);
    hread(reg_a(2), r); check("R9 len kept", r[36:16], 21'd3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule